// File: doc/BRIEF.md
# Priority Interrupt Controller Command Port

This block is the byte-wide register front end of an eight-line priority interrupt controller. Two addresses are chosen by a single address bit. Writes to address 0 either start a configuration sequence or carry a runtime command. Writes to address 1 feed the configuration words and, once the sequence is done, load the line mask. The block holds the configuration sequence state, the line mask, the vector base, the rotating priority base and the mode flags. It emits one-cycle clear pulses that the request and in-service registers outside the block apply.

The request register, the in-service register and the resolved winning line come from a separate capture and resolver stage. This block reads them. For a non-specific end-of-interrupt command, it picks the in-service line itself. The search starts at the rotating priority base and moves upward with wrap-around. A poll read returns the resolved line and also acknowledges it.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset every output is zero: mask, vector base, rotation base, all flags, all clear pulses and the read data.
- R2: A write to address 0 with bit 4 set starts configuration. It zeroes the mask, vector base, rotation base and the nested, auto-EOI, rotate-on-auto-EOI, read-select, special-mask and poll flags. It raises `busy_o`, pulses `init_o` for one cycle and records bit 0 as "fourth word expected".
- R3: While busy, address-1 writes advance the sequence and never touch the mask. The first sets the vector base from bits 7:3. The second ends the sequence unless a fourth word is expected. The fourth sets nested from bit 4 and auto-EOI from bit 1, then ends the sequence. When not busy, an address-1 write loads the mask.
- R4: If bit 1 or bit 3 of a configuration-start word is set, `cfg_err_o` is set. The flag is cleared only by reset.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set sets poll. Bit 1 set loads read-select from bit 0. Bit 6 set loads special-mask from bit 5.
- R6: An address-0 write with bits 4 and 3 clear and bits 6:5 zero loads rotate-on-auto-EOI from bit 7.
- R7: Command code 1 in bits 7:5 clears the highest-priority set in-service bit, searching from the rotation base upward modulo 8. Code 5 does the same and then sets the rotation base to that line plus 1. With the in-service register empty, neither code pulses a clear or changes the base.
- R8: Code 3 clears in-service line bits 2:0. Code 7 clears that line and sets the rotation base to it plus 1. Code 6 sets the rotation base to (bits 2:0 + 1) mod 8. Code 2 changes nothing.
- R9: A read while poll is set returns the resolved line in bits 2:0 and pulses that line's request and in-service clears. If no line is resolved, it returns 7 with no clear. Poll then clears.
- R10: A read without poll returns, from address 0, the in-service register when read-select is 1 and the request register otherwise. From address 1 it returns the mask.
- R11: Writes take effect at the clock edge that samples the strobe, and clear pulses last that one following cycle. Read data is registered and holds until the next read. If read and write strobe together, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| addr_i | input | 1 | Register address select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irr_i | input | 8 | Request register from capture stage |
| isr_i | input | 8 | In-service register |
| res_valid_i | input | 1 | Resolver has a winning line |
| res_line_i | input | 3 | Resolver winning line |
| imr_o | output | 8 | Line mask |
| vec_base_o | output | 5 | Vector base, upper bits |
| prio_base_o | output | 3 | Rotating priority base (highest-priority line) |
| isr_clr_o | output | 8 | One-cycle in-service clear pulse |
| irr_clr_o | output | 8 | One-cycle request clear pulse |
| init_o | output | 1 | Configuration start pulse, drops the interrupt output |
| busy_o | output | 1 | Configuration sequence in progress |
| nested_o | output | 1 | Nested mode flag |
| aeoi_o | output | 1 | Automatic end-of-interrupt flag |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt flag |
| read_sel_o | output | 1 | Address-0 read selects in-service register |
| smm_o | output | 1 | Special mask flag |
| poll_o | output | 1 | Next read is a poll read |
| cfg_err_o | output | 1 | Sticky unsupported-option flag |

## Verification
A write changes state and raises a clear pulse at the first rising edge after the strobe. Both can be seen for exactly that one cycle. Read data appears at the same edge and holds. The bench drives every strobe at a falling edge and drops it at the next falling edge. It samples state, pulses and read data at that second falling edge, so each check falls inside the one cycle in which a pulse is high.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_VEC  = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } cfg_st_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF = 3'd0,
    OP_NS_EOI  = 3'd1,
    OP_NOP     = 3'd2,
    OP_SP_EOI  = 3'd3,
    OP_ROT_ON  = 3'd4,
    OP_NS_ROT  = 3'd5,
    OP_SET_PRI = 3'd6,
    OP_SP_ROT  = 3'd7
  } op_code_e;
endpackage

// File: rtl/pic_rot_pick.sv
module pic_rot_pick #(
  parameter int NL = 8,
  parameter int LW = $clog2(NL)
) (
  input  logic [NL-1:0] req_i,
  input  logic [LW-1:0] base_i,
  output logic          hit_o,
  output logic [LW-1:0] line_o
);
  // walk from lowest to highest priority so the last hit wins
  always_comb begin
    logic [LW-1:0] idx;
    hit_o  = 1'b0;
    line_o = '0;
    for (int k = NL - 1; k >= 0; k--) begin
      idx = base_i + LW'(k);
      if (req_i[idx]) begin
        hit_o  = 1'b1;
        line_o = idx;
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int LW  = 3,
  parameter int VBW = DW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           init_i,
  input  logic           wr1_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [VBW-1:0] vec_base_o,
  output logic           nested_o,
  output logic           aeoi_o,
  output logic           cfg_err_o,
  output logic           busy_o,
  output logic           mask_we_o
);
  cfg_st_e st_q;
  logic    want4_q;
  logic    unused_bit;

  assign unused_bit = wdata_i[2];
  assign busy_o     = (st_q != ST_RUN);
  assign mask_we_o  = wr1_i && (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      want4_q    <= 1'b0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      aeoi_o     <= 1'b0;
      cfg_err_o  <= 1'b0;
    end else if (init_i) begin
      st_q       <= ST_VEC;
      want4_q    <= wdata_i[0];
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      aeoi_o     <= 1'b0;
      if (wdata_i[1] || wdata_i[3]) cfg_err_o <= 1'b1;
    end else if (wr1_i) begin
      unique case (st_q)
        ST_VEC: begin
          vec_base_o <= wdata_i[DW-1:LW];
          st_q       <= ST_CASC;
        end
        ST_CASC: st_q <= want4_q ? ST_MODE : ST_RUN;
        ST_MODE: begin
          nested_o <= wdata_i[4];
          aeoi_o   <= wdata_i[1];
          st_q     <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
  import pic_cmd_pkg::*;
#(
  parameter int NL = 8,
  parameter int LW = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NL-1:0] isr_i,
  input  logic          poll_rd_i,
  output logic [LW-1:0] prio_base_o,
  output logic          rot_aeoi_o,
  output logic          read_sel_o,
  output logic          smm_o,
  output logic          poll_o,
  output logic [NL-1:0] clr_o
);
  logic          mode_we, op_we, hit;
  logic [LW-1:0] top_line, arg_line, base_nxt;
  op_code_e      op;
  logic          unused_bit;

  assign unused_bit = wdata_i[4];
  assign mode_we    = cmd_we_i && wdata_i[3];
  assign op_we      = cmd_we_i && !wdata_i[3];
  assign op         = op_code_e'(wdata_i[7:5]);
  assign arg_line   = wdata_i[LW-1:0];

  pic_rot_pick #(.NL(NL), .LW(LW)) u_pick (
    .req_i  (isr_i),
    .base_i (prio_base_o),
    .hit_o  (hit),
    .line_o (top_line)
  );

  always_comb begin
    clr_o    = '0;
    base_nxt = prio_base_o;
    if (op_we) begin
      unique case (op)
        OP_NS_EOI: if (hit) clr_o[top_line] = 1'b1;
        OP_NS_ROT: if (hit) begin
          clr_o[top_line] = 1'b1;
          base_nxt        = top_line + LW'(1);
        end
        OP_SP_EOI:  clr_o[arg_line] = 1'b1;
        OP_SET_PRI: base_nxt = arg_line + LW'(1);
        OP_SP_ROT: begin
          clr_o[arg_line] = 1'b1;
          base_nxt        = arg_line + LW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_base_o <= '0;
      rot_aeoi_o  <= 1'b0;
      read_sel_o  <= 1'b0;
      smm_o       <= 1'b0;
      poll_o      <= 1'b0;
    end else if (init_i) begin
      prio_base_o <= '0;
      rot_aeoi_o  <= 1'b0;
      read_sel_o  <= 1'b0;
      smm_o       <= 1'b0;
      poll_o      <= 1'b0;
    end else begin
      if (poll_rd_i) poll_o <= 1'b0;
      if (op_we) begin
        prio_base_o <= base_nxt;
        if (op == OP_ROT_OFF || op == OP_ROT_ON) rot_aeoi_o <= wdata_i[7];
      end
      if (mode_we) begin
        if (wdata_i[2]) poll_o     <= 1'b1;
        if (wdata_i[1]) read_sel_o <= wdata_i[0];
        if (wdata_i[6]) smm_o      <= wdata_i[5];
      end
    end
  end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int NL  = 8,
  localparam int LW  = $clog2(NL),
  localparam int VBW = DW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic           addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NL-1:0]  irr_i,
  input  logic [NL-1:0]  isr_i,
  input  logic           res_valid_i,
  input  logic [LW-1:0]  res_line_i,
  output logic [NL-1:0]  imr_o,
  output logic [VBW-1:0] vec_base_o,
  output logic [LW-1:0]  prio_base_o,
  output logic [NL-1:0]  isr_clr_o,
  output logic [NL-1:0]  irr_clr_o,
  output logic           init_o,
  output logic           busy_o,
  output logic           nested_o,
  output logic           aeoi_o,
  output logic           rot_aeoi_o,
  output logic           read_sel_o,
  output logic           smm_o,
  output logic           poll_o,
  output logic           cfg_err_o
);
  logic          wr_eff, init_w, cmd_we, wr1, mask_we, poll_rd;
  logic [NL-1:0] cmd_clr, poll_clr;
  logic [DW-1:0] rd_val;

  // read wins a strobe collision
  assign wr_eff  = wr_i && !rd_i;
  assign init_w  = wr_eff && !addr_i && wdata_i[4];
  assign cmd_we  = wr_eff && !addr_i && !wdata_i[4];
  assign wr1     = wr_eff && addr_i;
  assign poll_rd = rd_i && poll_o;

  pic_init_seq #(.LW(LW), .VBW(VBW)) u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_w),
    .wr1_i      (wr1),
    .wdata_i    (wdata_i),
    .vec_base_o (vec_base_o),
    .nested_o   (nested_o),
    .aeoi_o     (aeoi_o),
    .cfg_err_o  (cfg_err_o),
    .busy_o     (busy_o),
    .mask_we_o  (mask_we)
  );

  pic_ocw_dec #(.NL(NL), .LW(LW)) u_ocw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_w),
    .cmd_we_i    (cmd_we),
    .wdata_i     (wdata_i),
    .isr_i       (isr_i),
    .poll_rd_i   (poll_rd),
    .prio_base_o (prio_base_o),
    .rot_aeoi_o  (rot_aeoi_o),
    .read_sel_o  (read_sel_o),
    .smm_o       (smm_o),
    .poll_o      (poll_o),
    .clr_o       (cmd_clr)
  );

  for (genvar g = 0; g < NL; g++) begin : g_poll_clr
    assign poll_clr[g] = poll_rd && res_valid_i && (res_line_i == LW'(g));
  end

  always_comb begin
    if (poll_o)       rd_val = res_valid_i ? DW'(res_line_i) : DW'(NL - 1);
    else if (addr_i)  rd_val = DW'(imr_o);
    else if (read_sel_o) rd_val = DW'(isr_i);
    else              rd_val = DW'(irr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_o     <= '0;
      rdata_o   <= '0;
      isr_clr_o <= '0;
      irr_clr_o <= '0;
      init_o    <= 1'b0;
    end else begin
      init_o    <= init_w;
      isr_clr_o <= cmd_clr | poll_clr;
      irr_clr_o <= poll_clr;
      if (rd_i) rdata_o <= rd_val;
      if (init_w)       imr_o <= '0;
      else if (mask_we) imr_o <= wdata_i[NL-1:0];
    end
  end
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk #(
  parameter int NL  = 8,
  localparam int LW  = $clog2(NL),
  localparam int VBW = 8 - LW
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_i,
  input logic           rd_i,
  input logic           addr_i,
  input logic [7:0]     wdata_i,
  input logic [7:0]     rdata_o,
  input logic [NL-1:0]  irr_i,
  input logic [NL-1:0]  isr_i,
  input logic           res_valid_i,
  input logic [LW-1:0]  res_line_i,
  input logic [NL-1:0]  imr_o,
  input logic [VBW-1:0] vec_base_o,
  input logic [LW-1:0]  prio_base_o,
  input logic [NL-1:0]  isr_clr_o,
  input logic [NL-1:0]  irr_clr_o,
  input logic           init_o,
  input logic           busy_o,
  input logic           nested_o,
  input logic           aeoi_o,
  input logic           rot_aeoi_o,
  input logic           read_sel_o,
  input logic           smm_o,
  input logic           poll_o,
  input logic           cfg_err_o
);
  logic unused_chk;
  assign unused_chk = ^{wdata_i, irr_i, isr_i, res_valid_i, res_line_i,
                        vec_base_o, nested_o, aeoi_o, rot_aeoi_o, smm_o};

  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> (imr_o == '0 && prio_base_o == '0 && !poll_o && !read_sel_o && busy_o)); // R2
  AST_BUSY_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_i && addr_i && !rd_i) |=> $stable(imr_o)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R4
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_clr_o)); // R7
  AST_POLL_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll_o) |=> !poll_o); // R9
  AST_REQ_CLR_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_clr_o != '0) |-> ((isr_clr_o & irr_clr_o) == irr_clr_o)); // R9
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(imr_o)); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R11
  AST_COLLIDE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && addr_i) |=> $stable(imr_o)); // R11
endmodule

bind pic_cmd_port pic_cmd_port_chk #(.NL(NL)) u_chk (.*);

// File: tb/pic_cmd_port_tb.sv
module pic_cmd_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 0, rd = 0, addr = 0, res_valid = 0;
  logic [7:0] wdata = 0, irr = 0, isr = 0;
  logic [2:0] res_line = 0;
  logic [7:0] rdata, imr, isr_clr, irr_clr;
  logic [4:0] vec_base;
  logic [2:0] prio_base;
  logic init_p, busy, nested, aeoi, rot_aeoi, read_sel, smm, poll, cfg_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_imr = 0, m_rdata = 0, e_isr_clr = 0, e_irr_clr = 0;
  logic [4:0] m_vb = 0;
  logic [2:0] m_pb = 0;
  int  m_st = 0;
  bit  m_want4 = 0, m_nest = 0, m_aeoi = 0, m_err = 0, m_rot = 0;
  bit  m_rsel = 0, m_smm = 0, m_poll = 0, e_init = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .isr_i(isr),
    .res_valid_i(res_valid), .res_line_i(res_line), .imr_o(imr),
    .vec_base_o(vec_base), .prio_base_o(prio_base), .isr_clr_o(isr_clr),
    .irr_clr_o(irr_clr), .init_o(init_p), .busy_o(busy), .nested_o(nested),
    .aeoi_o(aeoi), .rot_aeoi_o(rot_aeoi), .read_sel_o(read_sel), .smm_o(smm),
    .poll_o(poll), .cfg_err_o(cfg_err)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int top_isr(logic [7:0] s, logic [2:0] base);
    for (int k = 0; k < 8; k++) begin
      if (s[(base + k) % 8]) return (base + k) % 8;
    end
    return -1;
  endfunction

  task automatic check_all(string tag);
    chk({tag, " mask"}, imr, m_imr);
    chk({tag, " vbase"}, {3'b0, vec_base}, {3'b0, m_vb});
    chk({tag, " pbase"}, {5'b0, prio_base}, {5'b0, m_pb});
    chk({tag, " flags"}, {busy, nested, aeoi, cfg_err, rot_aeoi, read_sel, smm, poll},
        {m_st != 0, m_nest, m_aeoi, m_err, m_rot, m_rsel, m_smm, m_poll});
    chk({tag, " isr_clr"}, isr_clr, e_isr_clr);
    chk({tag, " irr_clr"}, irr_clr, e_irr_clr);
    chk({tag, " init"}, {7'b0, init_p}, {7'b0, e_init});
    chk({tag, " rdata"}, rdata, m_rdata);
  endtask

  task automatic model_write(logic a, logic [7:0] d);
    int ln;
    e_isr_clr = 0; e_irr_clr = 0; e_init = 0;
    if (!a && d[4]) begin
      e_init = 1; m_imr = 0; m_vb = 0; m_want4 = d[0]; m_st = 1;
      m_nest = 0; m_aeoi = 0; m_pb = 0; m_rot = 0; m_rsel = 0; m_smm = 0; m_poll = 0;
      if (d[1] || d[3]) m_err = 1;
    end else if (a) begin
      case (m_st)
        1: begin m_vb = d[7:3]; m_st = 2; end
        2: m_st = m_want4 ? 3 : 0;
        3: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
        default: m_imr = d;
      endcase
    end else if (d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smm = d[5];
    end else begin
      case (d[7:5])
        3'd0, 3'd4: m_rot = d[7];
        3'd1, 3'd5: begin
          ln = top_isr(isr, m_pb);
          if (ln >= 0) begin
            e_isr_clr = 8'(1 << ln);
            if (d[7:5] == 3'd5) m_pb = 3'(ln + 1);
          end
        end
        3'd3: e_isr_clr = 8'(1 << d[2:0]);
        3'd6: m_pb = d[2:0] + 3'd1;
        3'd7: begin e_isr_clr = 8'(1 << d[2:0]); m_pb = d[2:0] + 3'd1; end
        default: ;
      endcase
    end
  endtask

  task automatic model_read(logic a);
    e_isr_clr = 0; e_irr_clr = 0; e_init = 0;
    if (m_poll) begin
      m_rdata = res_valid ? {5'b0, res_line} : 8'd7;
      if (res_valid) begin e_isr_clr = 8'(1 << res_line); e_irr_clr = e_isr_clr; end
      m_poll = 0;
    end else if (a) m_rdata = m_imr;
    else m_rdata = m_rsel ? isr : irr;
  endtask

  task automatic do_wr(string tag, logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    model_write(a, d);
    @(negedge clk); wr = 0;
    check_all(tag);
  endtask

  task automatic do_rd(string tag, logic a);
    @(negedge clk); addr = a; rd = 1;
    model_read(a);
    @(negedge clk); rd = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // configuration with fourth word and bad option bits
    do_wr("R2 R4 start", 0, 8'h1B);
    do_wr("R3 vec", 1, 8'h48);
    do_wr("R3 casc", 1, 8'hFF);
    do_wr("R3 mode", 1, 8'h12);
    do_wr("R3 mask", 1, 8'hA5);
    do_rd("R10 mask rd", 1);
    // short sequence, err stays sticky
    do_wr("R2 R4 restart", 0, 8'h10);
    do_wr("R3 busy no mask", 1, 8'h20);
    do_wr("R3 end3", 1, 8'h33);
    do_wr("R3 mask2", 1, 8'h5A);

    // runtime commands
    isr = 8'b1001_0100;
    do_wr("R7 ns eoi", 0, 8'h20);
    do_wr("R8 set pri", 0, 8'hC4);
    isr = 8'b0001_0100;
    do_wr("R7 ns eoi rotated", 0, 8'h20);
    isr = 8'b1001_0000;
    do_wr("R7 ns rot", 0, 8'hA0);
    isr = 8'h00;
    do_wr("R7 empty eoi", 0, 8'h20);
    do_wr("R7 empty rot", 0, 8'hA0);
    do_wr("R8 sp eoi", 0, 8'h63);
    do_wr("R8 sp rot", 0, 8'hE6);
    do_wr("R8 nop", 0, 8'h40);
    do_wr("R8 wrap", 0, 8'hC7);
    do_wr("R6 rot on", 0, 8'h80);
    do_wr("R6 rot off", 0, 8'h00);

    // mode commands and reads
    isr = 8'h3C; irr = 8'hC3;
    do_wr("R5 rsel1", 0, 8'h0B);
    do_rd("R10 isr rd", 0);
    do_wr("R5 rsel0", 0, 8'h0A);
    do_rd("R10 irr rd", 0);
    do_wr("R5 smm1", 0, 8'h68);
    do_wr("R5 smm0", 0, 8'h48);
    do_wr("R5 poll", 0, 8'h0C);
    res_valid = 1; res_line = 3'd5;
    do_rd("R9 poll hit", 0);
    do_wr("R5 poll2", 0, 8'h0C);
    res_valid = 0;
    do_rd("R9 poll idle", 1);
    do_rd("R9 after poll", 1);

    // R11 collision: write dropped, read served
    @(negedge clk); addr = 1; wdata = 8'h0F; wr = 1; rd = 1;
    model_read(1);
    @(negedge clk); wr = 0; rd = 0;
    check_all("R11 collide");

    for (int i = 0; i < 400; i++) begin
      int r;
      @(negedge clk);
      isr = 8'($urandom); irr = 8'($urandom);
      res_valid = 1'($urandom); res_line = 3'($urandom);
      r = $urandom_range(0, 19);
      if (r < 5)       do_rd("R9 R10 rand rd", 1'($urandom));
      else if (r < 9)  do_wr("R3 rand a1", 1, 8'($urandom));
      else if (r < 19) do_wr("R5 R6 R7 R8 rand cmd", 0, 8'($urandom) & 8'hEF);
      else             do_wr("R2 rand init", 0, 8'h10 | (8'($urandom) & 8'h0F));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule